// File: doc/BRIEF.md
# TFT Line Control Pulse Generator

This block drives the extra per-line control signals needed by a reflective high-resolution TFT panel. Two control outputs and an offset frame pulse each switch high and low at programmed pixel-clock positions measured from the start of every line. The block also drives a static select that tells the shift-clock logic which edge to use. The base horizontal and vertical timing are generated elsewhere. This block only receives a line-start strobe and a frame-start strobe from that timing and counts pixel clocks from each line start.

Software programs four 32-bit words through a simple write/read port. One word holds the mode bits, and each of the other three holds a start/stop pixel pair for one output. All programmed values are copied into an active set on the next line-start strobe. A pulse therefore never changes shape partway through a line. Mode bits choose between programmed pulses and fixed-low outputs, let the second control output toggle once per line instead of pulsing, exchange the two control outputs, and pick the shift-clock edge.

Top module: `tft_ctl_pulse_gen`

## Requirements
- R1: After reset every register reads 0, and all four outputs are low.
- R2: The word address selects the register: 0 is mode, 1 is frame pulse, 2 is control 0 and 3 is control 1. In the mode word, bit 0 is swap, bit 1 is shift edge, bit 2 is preset enable and bit 3 is control-1 program mode. In each offset word the start offset is in bits 9:0 and the stop offset is in bits 25:16. Read data appears one clock after the address, and unused bit positions always read 0.
- R3: The pixel counter restarts on each line-start strobe. The clock period right after the edge that samples the strobe is pixel 0. With preset enabled, control 0 is high exactly in pixels start..stop inclusive, so it falls at stop+1.
- R4: A window whose stop offset is below its start offset produces no high pixel in that line.
- R5: With preset enable 0, control 0 stays low, and control 1 in program mode also stays low, whatever the offsets hold.
- R6: With preset enable 1 and program mode 1, control 1 is high exactly in pixels start..stop of its own window.
- R7: With program mode 0, control 1 ignores its offsets. It is low after reset, changes level on each line-start strobe and holds that level for the whole line.
- R8: With swap set, the control 0 output carries the control 1 signal and the control 1 output carries the control 0 signal.
- R9: The shift-edge output equals the active shift-edge bit, where 1 means rising and 0 means falling.
- R10: The frame pulse is high in pixels start..stop of its window, and only in a line whose line-start strobe came with the frame-start strobe. A window of 0/0 gives a single pulse at pixel 0.
- R11: Register writes change the outputs only from the next line-start strobe onward, so the current line keeps its old shape.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| line_start_i | input | 1 | One-cycle strobe at the start of each line |
| frame_start_i | input | 1 | Marks the line whose strobe opens a frame (sampled with line_start_i) |
| reg_we_i | input | 1 | Register write enable |
| reg_addr_i | input | 2 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Registered read data for the previous address |
| ctl0_o | output | 1 | Control output 0 |
| ctl1_o | output | 1 | Control output 1 |
| frame_pulse_o | output | 1 | Offset frame pulse |
| shift_rise_o | output | 1 | Shift-clock edge select (1 rising, 0 falling) |

## Verification
The assertions assume that the line-start strobe is a single-cycle pulse and that the frame-start strobe only matters in that same cycle. They also assume that a line-start strobe arrives before any output is expected to follow the programmed values. The bench meets these conditions by raising each strobe for exactly one clock, by pairing frame-start only with a line-start, and by writing registers either between lines or in pixel 0 of a line under test. Lines are kept short (twelve pixels) so every window edge falls inside the sampled range, and the counter never reaches saturation during a checked line.

// File: rtl/tft_ctl_pkg.sv
package tft_ctl_pkg;
  localparam int OFS_W    = 10;
  localparam int REG_W    = 32;
  localparam int ADDR_W   = 2;
  localparam int STOP_LSB = 16;
  localparam int N_WIN    = 3;

  typedef struct packed {
    logic [OFS_W-1:0] stop;
    logic [OFS_W-1:0] start;
  } win_t;

  typedef struct packed {
    logic ctl1_prog;
    logic preset;
    logic shift_rise;
    logic swap;
  } mode_t;

  typedef struct packed {
    mode_t mode;
    win_t  frm;
    win_t  c0;
    win_t  c1;
  } cfg_t;

  localparam logic [ADDR_W-1:0] A_MODE = 2'd0;
  localparam logic [ADDR_W-1:0] A_FRM  = 2'd1;
  localparam logic [ADDR_W-1:0] A_C0   = 2'd2;
  localparam logic [ADDR_W-1:0] A_C1   = 2'd3;
endpackage

// File: rtl/tft_ctl_regs.sv
module tft_ctl_regs
  import tft_ctl_pkg::*;
#(
  parameter int DW = REG_W,
  parameter int AW = ADDR_W,
  parameter int SL = STOP_LSB
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output cfg_t          cfg_o
);
  localparam int MODE_W = $bits(mode_t);

  cfg_t            cfg_q;
  logic [DW-1:0]   rd_nxt;

  function automatic logic [DW-1:0] win_word(input win_t w);
    logic [DW-1:0] r;
    r = '0;
    r[OFS_W-1:0]   = w.start;
    r[SL +: OFS_W] = w.stop;
    return r;
  endfunction

  function automatic win_t word_win(input logic [DW-1:0] d);
    win_t w;
    w.start = d[OFS_W-1:0];
    w.stop  = d[SL +: OFS_W];
    return w;
  endfunction

  function automatic logic [DW-1:0] used_mask(input logic [AW-1:0] a);
    logic [DW-1:0] m;
    m = '0;
    if (a == A_MODE) m[MODE_W-1:0] = '1;
    else begin
      m[OFS_W-1:0]   = '1;
      m[SL +: OFS_W] = '1;
    end
    return m;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
    end else if (we_i) begin
      case (addr_i)
        A_MODE:  cfg_q.mode <= mode_t'(wdata_i[MODE_W-1:0]);
        A_FRM:   cfg_q.frm  <= word_win(wdata_i);
        A_C0:    cfg_q.c0   <= word_win(wdata_i);
        default: cfg_q.c1   <= word_win(wdata_i);
      endcase
    end
  end

  always_comb begin
    rd_nxt = '0;
    case (addr_i)
      A_MODE:  rd_nxt[MODE_W-1:0] = cfg_q.mode;
      A_FRM:   rd_nxt = win_word(cfg_q.frm);
      A_C0:    rd_nxt = win_word(cfg_q.c0);
      default: rd_nxt = win_word(cfg_q.c1);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_o <= '0;
    else     rdata_o <= rd_nxt;
  end

  assign cfg_o = cfg_q;

  // R2: unused positions of the returned word are always zero
  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((rdata_o & ~used_mask($past(addr_i))) == '0));
endmodule

// File: rtl/tft_line_timer.sv
module tft_line_timer
  import tft_ctl_pkg::*;
#(
  parameter int CW = OFS_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          line_start_i,
  input  logic          frame_start_i,
  input  cfg_t          cfg_i,
  output logic [CW-1:0] cnt_nxt_o,
  output cfg_t          cfg_nxt_o,
  output logic          frame_nxt_o,
  output logic          tog_nxt_o,
  output cfg_t          act_cfg_o
);
  localparam logic [CW-1:0] CNT_MAX = '1;

  logic [CW-1:0] cnt_q;
  cfg_t          act_q;
  logic          frame_q;
  logic          tog_q;

  always_comb begin
    if (line_start_i)           cnt_nxt_o = '0;
    else if (cnt_q == CNT_MAX)  cnt_nxt_o = cnt_q;
    else                        cnt_nxt_o = cnt_q + CW'(1);
    cfg_nxt_o   = line_start_i ? cfg_i         : act_q;
    frame_nxt_o = line_start_i ? frame_start_i : frame_q;
    tog_nxt_o   = line_start_i ? ~tog_q        : tog_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      act_q   <= '0;
      frame_q <= 1'b0;
      tog_q   <= 1'b0;
    end else begin
      cnt_q   <= cnt_nxt_o;
      act_q   <= cfg_nxt_o;
      frame_q <= frame_nxt_o;
      tog_q   <= tog_nxt_o;
    end
  end

  assign act_cfg_o = act_q;

  assert_cnt_restart_R3: assert property (@(posedge clk) disable iff (rst)
    line_start_i |=> (cnt_q == '0));

  assert_shadow_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !line_start_i |=> $stable(act_q));

  assert_toggle_flip_R7: assert property (@(posedge clk) disable iff (rst)
    line_start_i |=> (tog_q != $past(tog_q)));

  assert_toggle_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !line_start_i |=> $stable(tog_q));
endmodule

// File: rtl/tft_pulse_win.sv
module tft_pulse_win
  import tft_ctl_pkg::*;
#(
  parameter int CW = OFS_W
) (
  input  logic [CW-1:0] cnt_i,
  input  win_t          win_i,
  output logic          hit_o
);
  always_comb hit_o = (cnt_i >= win_i.start) && (cnt_i <= win_i.stop);
endmodule

// File: rtl/tft_ctl_pulse_gen.sv
module tft_ctl_pulse_gen
  import tft_ctl_pkg::*;
#(
  parameter int CW = OFS_W,
  parameter int DW = REG_W,
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          line_start_i,
  input  logic          frame_start_i,
  input  logic          reg_we_i,
  input  logic [AW-1:0] reg_addr_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  output logic          ctl0_o,
  output logic          ctl1_o,
  output logic          frame_pulse_o,
  output logic          shift_rise_o
);
  cfg_t          prog_cfg;
  cfg_t          cfg_nxt;
  cfg_t          act_cfg;
  logic [CW-1:0] cnt_nxt;
  logic          frame_nxt;
  logic          tog_nxt;
  win_t          wins [N_WIN];
  logic [N_WIN-1:0] hit;
  logic          c0_raw, c1_raw, fp_raw;

  tft_ctl_regs #(.DW(DW), .AW(AW), .SL(STOP_LSB)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .rdata_o (reg_rdata_o),
    .cfg_o   (prog_cfg)
  );

  tft_line_timer #(.CW(CW)) u_timer (
    .clk           (clk),
    .rst           (rst),
    .line_start_i  (line_start_i),
    .frame_start_i (frame_start_i),
    .cfg_i         (prog_cfg),
    .cnt_nxt_o     (cnt_nxt),
    .cfg_nxt_o     (cfg_nxt),
    .frame_nxt_o   (frame_nxt),
    .tog_nxt_o     (tog_nxt),
    .act_cfg_o     (act_cfg)
  );

  assign wins[0] = cfg_nxt.c0;
  assign wins[1] = cfg_nxt.c1;
  assign wins[2] = cfg_nxt.frm;

  for (genvar g = 0; g < N_WIN; g++) begin : g_win
    tft_pulse_win #(.CW(CW)) u_win (
      .cnt_i (cnt_nxt),
      .win_i (wins[g]),
      .hit_o (hit[g])
    );
  end

  always_comb begin
    c0_raw = cfg_nxt.mode.preset & hit[0];
    c1_raw = cfg_nxt.mode.ctl1_prog ? (cfg_nxt.mode.preset & hit[1]) : tog_nxt;
    fp_raw = frame_nxt & hit[2];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl0_o        <= 1'b0;
      ctl1_o        <= 1'b0;
      frame_pulse_o <= 1'b0;
      shift_rise_o  <= 1'b0;
    end else begin
      ctl0_o        <= cfg_nxt.mode.swap ? c1_raw : c0_raw;
      ctl1_o        <= cfg_nxt.mode.swap ? c0_raw : c1_raw;
      frame_pulse_o <= fp_raw;
      shift_rise_o  <= cfg_nxt.mode.shift_rise;
    end
  end

  assert_preset_off_low_R5: assert property (@(posedge clk) disable iff (rst)
    (!act_cfg.mode.preset && act_cfg.mode.ctl1_prog) |-> (!ctl0_o && !ctl1_o));

  assert_shift_follows_R9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |-> (shift_rise_o == act_cfg.mode.shift_rise));
endmodule

// File: tb/test_tft_ctl_pulse_gen.sv
`timescale 1ns/1ps
module test_tft_ctl_pulse_gen;
  localparam int LEN = 12;
  localparam logic [31:0] M_SWAP = 32'h1, M_SHIFT = 32'h2, M_PRESET = 32'h4, M_PROG = 32'h8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic line_start = 1'b0, frame_start = 1'b0, we = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic ctl0, ctl1, fp, shift;

  logic cap0 [LEN], cap1 [LEN], capf [LEN];
  logic exp_tog = 1'b0;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  tft_ctl_pulse_gen i_tft_ctl_pulse_gen (
    .clk(clk), .rst(rst), .line_start_i(line_start), .frame_start_i(frame_start),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .ctl0_o(ctl0), .ctl1_o(ctl1), .frame_pulse_o(fp), .shift_rise_o(shift)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic in_win(input int n, input int s, input int e);
    return (n >= s) && (n <= e);
  endfunction

  function automatic logic [31:0] win(input int s, input int e);
    return (32'(e) << 16) | 32'(s);
  endfunction

  task automatic write_reg(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic read_check(input logic [1:0] a, input logic [31:0] e, input string tag);
    @(negedge clk); addr = a;
    @(negedge clk);
    check(rdata == e, tag, rdata, e);
  endtask

  task automatic run_line(input logic fs, input bit do_wr, input logic [1:0] wa, input logic [31:0] wd);
    @(negedge clk); line_start = 1'b1; frame_start = fs;
    @(negedge clk); line_start = 1'b0; frame_start = 1'b0; exp_tog = ~exp_tog;
    for (int n = 0; n < LEN; n++) begin
      cap0[n] = ctl0; cap1[n] = ctl1; capf[n] = fp;
      if (n == 0 && do_wr) begin we = 1'b1; addr = wa; wdata = wd; end
      else we = 1'b0;
      @(negedge clk);
    end
    we = 1'b0;
  endtask

  // which: 0 ctl0, 1 ctl1, 2 frame pulse; window s..e
  task automatic check_line(input int which, input int s, input int e, input string tag);
    int bad = -1;
    logic got, exp;
    for (int n = 0; n < LEN; n++) begin
      got = (which == 0) ? cap0[n] : (which == 1) ? cap1[n] : capf[n];
      exp = in_win(n, s, e);
      if (got !== exp && bad < 0) bad = n;
    end
    if (bad < 0) check(1'b1, tag, 0, 0);
    else begin
      got = (which == 0) ? cap0[bad] : (which == 1) ? cap1[bad] : capf[bad];
      check(1'b0, $sformatf("%s pixel %0d", tag, bad), 32'(got), 32'(in_win(bad, s, e)));
    end
  endtask

  task automatic t_reset;
    check({ctl0, ctl1, fp, shift} == 4'b0, "R1 outputs after reset", {ctl0, ctl1, fp, shift}, 0);
    for (int a = 0; a < 4; a++) read_check(2'(a), 32'h0, "R1 register reset value");
  endtask

  task automatic t_readback;
    for (int a = 0; a < 4; a++) write_reg(2'(a), 32'hFFFF_FFFF);
    read_check(2'd0, 32'h0000_000F, "R2 mode read mask");
    for (int a = 1; a < 4; a++) read_check(2'(a), 32'h03FF_03FF, "R2 offset read mask");
    write_reg(2'd2, win(5, 9));
    read_check(2'd2, win(5, 9), "R2 ctl0 word fields");
  endtask

  task automatic t_ctl0_window;
    write_reg(2'd0, M_PRESET | M_PROG);
    write_reg(2'd2, win(3, 6));
    write_reg(2'd3, win(20, 25));
    write_reg(2'd1, win(0, 0));
    run_line(1'b0, 0, 0, 0);
    check_line(0, 3, 6, "R3 ctl0 window 3..6");
    check_line(1, 20, 25, "R6 ctl1 window out of line");
  endtask

  task automatic t_ctl1_window;
    write_reg(2'd3, win(0, 2));
    run_line(1'b0, 0, 0, 0);
    check_line(1, 0, 2, "R6 ctl1 window 0..2");
  endtask

  task automatic t_inverted;
    write_reg(2'd2, win(7, 2));
    run_line(1'b0, 0, 0, 0);
    check_line(0, 1, 0, "R4 stop below start never high");
  endtask

  task automatic t_preset_off;
    write_reg(2'd2, win(1, 8));
    write_reg(2'd0, M_PROG);
    run_line(1'b0, 0, 0, 0);
    check_line(0, 1, 0, "R5 ctl0 low without preset");
    check_line(1, 1, 0, "R5 ctl1 low without preset");
  endtask

  task automatic t_toggle;
    write_reg(2'd0, M_PRESET);
    for (int k = 0; k < 2; k++) begin
      run_line(1'b0, 0, 0, 0);
      if (exp_tog) check_line(1, 0, LEN, "R7 toggle level high");
      else         check_line(1, 1, 0, "R7 toggle level low");
    end
  endtask

  task automatic t_swap;
    write_reg(2'd2, win(3, 6));
    write_reg(2'd3, win(0, 2));
    write_reg(2'd0, M_PRESET | M_PROG | M_SWAP);
    run_line(1'b0, 0, 0, 0);
    check_line(0, 0, 2, "R8 ctl0 pin carries ctl1");
    check_line(1, 3, 6, "R8 ctl1 pin carries ctl0");
  endtask

  task automatic t_shift;
    write_reg(2'd0, M_PRESET | M_PROG | M_SHIFT);
    check(shift == 1'b0, "R9 R11 shift edge before line start", 32'(shift), 0);
    run_line(1'b0, 0, 0, 0);
    check(shift == 1'b1, "R9 shift edge rising", 32'(shift), 1);
    write_reg(2'd0, M_PRESET | M_PROG);
    run_line(1'b0, 0, 0, 0);
    check(shift == 1'b0, "R9 shift edge falling", 32'(shift), 0);
  endtask

  task automatic t_frame;
    write_reg(2'd1, win(2, 4));
    run_line(1'b1, 0, 0, 0);
    check_line(2, 2, 4, "R10 frame pulse 2..4");
    run_line(1'b0, 0, 0, 0);
    check_line(2, 1, 0, "R10 no frame pulse without frame start");
    write_reg(2'd1, win(0, 0));
    run_line(1'b1, 0, 0, 0);
    check_line(2, 0, 0, "R10 zero offsets single pixel");
  endtask

  task automatic t_midline;
    write_reg(2'd2, win(3, 6));
    run_line(1'b0, 1, 2'd2, win(8, 10));
    check_line(0, 3, 6, "R11 current line keeps old window");
    run_line(1'b0, 0, 0, 0);
    check_line(0, 8, 10, "R11 next line uses new window");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_readback();
    t_ctl0_window();
    t_ctl1_window();
    t_inverted();
    t_preset_off();
    t_toggle();
    t_swap();
    t_shift();
    t_frame();
    t_midline();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule